// File: doc/BRIEF.md
# Bank-Switched Dual-Port Shared Memory

This block is a clocked shared memory with two fully independent access ports, called left and right. The storage is divided into equal banks. Each bank belongs to exactly one port at a time, and a static ownership input per bank decides which port that is. A port addresses a bank with a bank index plus a word offset inside the bank. It reads and writes the banks it owns without restriction. An access to a bank owned by the other port is blocked and reported. There is no arbitration between the ports, and neither port ever waits.

Each access is qualified by a pair of chip selects, one active low and one active high, and by a side-space select that must be inactive. Per-lane byte enables then pick the bytes that are written or returned. A read returns its data one cycle after it is issued, together with a valid strobe. When the read was blocked, the data is all zeros and an error flag is raised. The default configuration has four banks of 256 words of 16 bits. The word-address parameter can be raised to 13 for 8K-word banks.

Top module: `banked_dualport_ram`

## Requirements
- R1: Bit b of `bank_owner_left` gives bank b to the left port when it is 1 and to the right port when it is 0. Each bank is assigned independently, so one port may own anywhere from zero to all banks.
- R2: A qualified write by the owning port stores `wdata` only in the byte lanes whose `be` bit is 1. Bit 0 is the lower byte (bits 7:0) and bit 1 is the upper byte (bits 15:8). All other lanes keep their contents.
- R3: A write to a bank the port does not own leaves the memory unchanged.
- R4: A qualified read of a bank the port does not own returns `rdata` = 0 with `rvalid` = 1 and `err` = 1 on the following cycle.
- R5: A qualified read of an owned bank returns the stored word on the following cycle, with `rvalid` = 1 and `err` = 0. In every other cycle `rvalid` is 0.
- R6: In read data, any lane whose `be` bit was 0 reads as zero. An access with `be` = 0 writes nothing and produces neither `rvalid` nor `err`.
- R7: An access is qualified only when `cs0_n` = 0, `cs1` = 1 and `mbox_sel` = 0. Otherwise it writes nothing and produces neither `rvalid` nor `err`.
- R8: The two ports can access different banks in the same cycle, and neither access affects the other.
- R9: When both ports write the same bank and word in one cycle, only the owning port's data is stored.
- R10: A blocked write raises `err` for one cycle on the following cycle, with `rvalid` = 0.
- R11: While `rst_n` is low, `rvalid`, `err` and `rdata` are 0 on both ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_owner_left | input | NUM_BANKS (4) | Per-bank owner: 1 = left port, 0 = right port |
| l_cs0_n | input | 1 | Left chip select, active low |
| l_cs1 | input | 1 | Left chip select, active high |
| l_mbox_sel | input | 1 | Left side-space select; memory is accessed only while 0 |
| l_we | input | 1 | Left write (1) or read (0) |
| l_bank | input | BANK_AW (2) | Left bank index |
| l_addr | input | WORD_AW (8) | Left word offset in bank |
| l_be | input | DATA_W/LANE_W (2) | Left byte enables, bit 0 = lower byte |
| l_wdata | input | DATA_W (16) | Left write data |
| l_rdata | output | DATA_W (16) | Left read data |
| l_rvalid | output | 1 | Left read data valid |
| l_err | output | 1 | Left blocked-access flag |
| r_cs0_n | input | 1 | Right chip select, active low |
| r_cs1 | input | 1 | Right chip select, active high |
| r_mbox_sel | input | 1 | Right side-space select; memory is accessed only while 0 |
| r_we | input | 1 | Right write (1) or read (0) |
| r_bank | input | BANK_AW (2) | Right bank index |
| r_addr | input | WORD_AW (8) | Right word offset in bank |
| r_be | input | DATA_W/LANE_W (2) | Right byte enables, bit 0 = lower byte |
| r_wdata | input | DATA_W (16) | Right write data |
| r_rdata | output | DATA_W (16) | Right read data |
| r_rvalid | output | 1 | Right read data valid |
| r_err | output | 1 | Right blocked-access flag |

## Verification
The assertions assume that the ownership map never changes while either port is reading the affected bank. A read result is checked against the owner bit as sampled one cycle earlier, so a change of owner during a read would make that check meaningless. The stimulus therefore changes `bank_owner_left` only in a cycle when both ports are idle, and it walks through all sixteen ownership patterns that way. Inputs are held idle throughout reset, so the first cycle after reset has no access in flight that the checks would see.

// File: rtl/bdp_pkg.sv
package bdp_pkg;
   // Which side of the memory a port front-end serves.
   typedef enum logic {
      SIDE_RIGHT = 1'b0,
      SIDE_LEFT  = 1'b1
   } side_e;

   localparam int DEF_DATA_W  = 16;
   localparam int DEF_LANE_W  = 8;
   localparam int DEF_BANK_AW = 2;
   localparam int DEF_WORD_AW = 8;
endpackage

// File: rtl/bdp_port_front.sv
module bdp_port_front
   import bdp_pkg::*;
#(
   parameter int    BANK_AW      = DEF_BANK_AW,
   parameter int    NUM_LANES    = 2,
   parameter side_e SIDE         = SIDE_LEFT,
   parameter bit    ERR_ON_WRITE = 1'b1,
   localparam int   NUM_BANKS    = 1 << BANK_AW
) (
   input  logic                 cs0_n,
   input  logic                 cs1,
   input  logic                 mbox_sel,
   input  logic                 we,
   input  logic [BANK_AW-1:0]   bank,
   input  logic [NUM_LANES-1:0] be,
   input  logic [NUM_BANKS-1:0] owner_map,
   output logic                 rd_any,
   output logic                 owned,
   output logic                 wr_go,
   output logic                 rd_go,
   output logic                 blocked
);
   logic port_sel;
   logic acc;
   logic side_bit;

   assign side_bit = (SIDE == SIDE_LEFT);
   assign port_sel = !cs0_n && cs1 && !mbox_sel;
   assign acc      = port_sel && (|be);
   assign owned    = (owner_map[bank] == side_bit);
   assign rd_any   = acc && !we;
   assign wr_go    = acc && we && owned;
   assign rd_go    = rd_any && owned;

   generate
      if (ERR_ON_WRITE) begin : g_flag_all
         assign blocked = acc && !owned;
      end else begin : g_flag_reads
         assign blocked = rd_any && !owned;
      end
   endgenerate
endmodule

// File: rtl/bdp_bank.sv
module bdp_bank #(
   parameter int  DATA_W    = 16,
   parameter int  LANE_W    = 8,
   parameter int  WORD_AW   = 8,
   localparam int NUM_LANES = DATA_W / LANE_W,
   localparam int DEPTH     = 1 << WORD_AW
) (
   input  logic                 clk,
   input  logic                 owner_left,
   input  logic                 l_wr,
   input  logic                 l_rd,
   input  logic [WORD_AW-1:0]   l_addr,
   input  logic [NUM_LANES-1:0] l_be,
   input  logic [DATA_W-1:0]    l_wdata,
   input  logic                 r_wr,
   input  logic                 r_rd,
   input  logic [WORD_AW-1:0]   r_addr,
   input  logic [NUM_LANES-1:0] r_be,
   input  logic [DATA_W-1:0]    r_wdata,
   output logic [DATA_W-1:0]    rdata
);
   logic [DATA_W-1:0]    mem [DEPTH];
   logic                 wr, rd;
   logic [WORD_AW-1:0]   addr;
   logic [NUM_LANES-1:0] be;
   logic [DATA_W-1:0]    wdata;

   // Only the owning side reaches the array.
   always_comb begin
      if (owner_left) begin
         wr = l_wr; rd = l_rd; addr = l_addr; be = l_be; wdata = l_wdata;
      end else begin
         wr = r_wr; rd = r_rd; addr = r_addr; be = r_be; wdata = r_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (wr) begin
         for (int k = 0; k < NUM_LANES; k++) begin
            if (be[k]) mem[addr][k*LANE_W +: LANE_W] <= wdata[k*LANE_W +: LANE_W];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rd) rdata <= mem[addr];
   end
endmodule

// File: rtl/bdp_port_return.sv
module bdp_port_return #(
   parameter int  DATA_W    = 16,
   parameter int  LANE_W    = 8,
   parameter int  BANK_AW   = 2,
   localparam int NUM_LANES = DATA_W / LANE_W,
   localparam int NUM_BANKS = 1 << BANK_AW
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              rd_any,
   input  logic                              owned,
   input  logic                              blocked,
   input  logic [BANK_AW-1:0]                bank,
   input  logic [NUM_LANES-1:0]              be,
   input  logic [NUM_BANKS-1:0][DATA_W-1:0]  bank_rdata,
   output logic [DATA_W-1:0]                 rdata,
   output logic                              rvalid,
   output logic                              err
);
   logic                 own_q;
   logic [BANK_AW-1:0]   bank_q;
   logic [NUM_LANES-1:0] be_q;
   logic [DATA_W-1:0]    picked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rvalid <= 1'b0;
         err    <= 1'b0;
         own_q  <= 1'b0;
         bank_q <= '0;
         be_q   <= '0;
      end else begin
         rvalid <= rd_any;
         err    <= blocked;
         own_q  <= owned;
         bank_q <= bank;
         be_q   <= be;
      end
   end

   assign picked = bank_rdata[bank_q];

   for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
      assign rdata[k*LANE_W +: LANE_W] =
         (rvalid && own_q && be_q[k]) ? picked[k*LANE_W +: LANE_W] : '0;
   end
endmodule

// File: rtl/banked_dualport_ram.sv
module banked_dualport_ram
   import bdp_pkg::*;
#(
   parameter int  DATA_W       = DEF_DATA_W,
   parameter int  LANE_W       = DEF_LANE_W,
   parameter int  BANK_AW      = DEF_BANK_AW,
   parameter int  WORD_AW      = DEF_WORD_AW,
   parameter bit  ERR_ON_WRITE = 1'b1,
   localparam int NUM_LANES    = DATA_W / LANE_W,
   localparam int NUM_BANKS    = 1 << BANK_AW
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_BANKS-1:0] bank_owner_left,
   input  logic                 l_cs0_n,
   input  logic                 l_cs1,
   input  logic                 l_mbox_sel,
   input  logic                 l_we,
   input  logic [BANK_AW-1:0]   l_bank,
   input  logic [WORD_AW-1:0]   l_addr,
   input  logic [NUM_LANES-1:0] l_be,
   input  logic [DATA_W-1:0]    l_wdata,
   output logic [DATA_W-1:0]    l_rdata,
   output logic                 l_rvalid,
   output logic                 l_err,
   input  logic                 r_cs0_n,
   input  logic                 r_cs1,
   input  logic                 r_mbox_sel,
   input  logic                 r_we,
   input  logic [BANK_AW-1:0]   r_bank,
   input  logic [WORD_AW-1:0]   r_addr,
   input  logic [NUM_LANES-1:0] r_be,
   input  logic [DATA_W-1:0]    r_wdata,
   output logic [DATA_W-1:0]    r_rdata,
   output logic                 r_rvalid,
   output logic                 r_err
);
   // Elaboration-time parameter checks.
   if (LANE_W < 1 || (DATA_W % LANE_W) != 0) begin : g_bad_lane
      $error("DATA_W must be a whole number of LANE_W lanes");
   end
   if (BANK_AW < 1 || WORD_AW < 1) begin : g_bad_addr
      $error("BANK_AW and WORD_AW must be at least 1");
   end

   logic l_rd_any, l_owned, l_wr_go, l_rd_go, l_blocked;
   logic r_rd_any, r_owned, r_wr_go, r_rd_go, r_blocked;
   logic [NUM_BANKS-1:0][DATA_W-1:0] bank_rdata;

   bdp_port_front #(
      .BANK_AW(BANK_AW), .NUM_LANES(NUM_LANES),
      .SIDE(SIDE_LEFT), .ERR_ON_WRITE(ERR_ON_WRITE)
   ) u_front_l (
      .cs0_n(l_cs0_n), .cs1(l_cs1), .mbox_sel(l_mbox_sel), .we(l_we),
      .bank(l_bank), .be(l_be), .owner_map(bank_owner_left),
      .rd_any(l_rd_any), .owned(l_owned), .wr_go(l_wr_go),
      .rd_go(l_rd_go), .blocked(l_blocked)
   );

   bdp_port_front #(
      .BANK_AW(BANK_AW), .NUM_LANES(NUM_LANES),
      .SIDE(SIDE_RIGHT), .ERR_ON_WRITE(ERR_ON_WRITE)
   ) u_front_r (
      .cs0_n(r_cs0_n), .cs1(r_cs1), .mbox_sel(r_mbox_sel), .we(r_we),
      .bank(r_bank), .be(r_be), .owner_map(bank_owner_left),
      .rd_any(r_rd_any), .owned(r_owned), .wr_go(r_wr_go),
      .rd_go(r_rd_go), .blocked(r_blocked)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic l_hit, r_hit;
      assign l_hit = (l_bank == BANK_AW'(b));
      assign r_hit = (r_bank == BANK_AW'(b));

      bdp_bank #(
         .DATA_W(DATA_W), .LANE_W(LANE_W), .WORD_AW(WORD_AW)
      ) u_bank (
         .clk(clk), .owner_left(bank_owner_left[b]),
         .l_wr(l_wr_go && l_hit), .l_rd(l_rd_go && l_hit),
         .l_addr(l_addr), .l_be(l_be), .l_wdata(l_wdata),
         .r_wr(r_wr_go && r_hit), .r_rd(r_rd_go && r_hit),
         .r_addr(r_addr), .r_be(r_be), .r_wdata(r_wdata),
         .rdata(bank_rdata[b])
      );
   end

   bdp_port_return #(
      .DATA_W(DATA_W), .LANE_W(LANE_W), .BANK_AW(BANK_AW)
   ) u_ret_l (
      .clk(clk), .rst_n(rst_n), .rd_any(l_rd_any), .owned(l_owned),
      .blocked(l_blocked), .bank(l_bank), .be(l_be), .bank_rdata(bank_rdata),
      .rdata(l_rdata), .rvalid(l_rvalid), .err(l_err)
   );

   bdp_port_return #(
      .DATA_W(DATA_W), .LANE_W(LANE_W), .BANK_AW(BANK_AW)
   ) u_ret_r (
      .clk(clk), .rst_n(rst_n), .rd_any(r_rd_any), .owned(r_owned),
      .blocked(r_blocked), .bank(r_bank), .be(r_be), .bank_rdata(bank_rdata),
      .rdata(r_rdata), .rvalid(r_rvalid), .err(r_err)
   );
endmodule

// File: rtl/bdp_chk.sv
module bdp_chk #(
   parameter int  DATA_W    = 16,
   parameter int  LANE_W    = 8,
   parameter int  BANK_AW   = 2,
   parameter int  WORD_AW   = 8,
   localparam int NUM_LANES = DATA_W / LANE_W,
   localparam int NUM_BANKS = 1 << BANK_AW
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_BANKS-1:0] bank_owner_left,
   input logic                 l_cs0_n,
   input logic                 l_cs1,
   input logic                 l_mbox_sel,
   input logic                 l_we,
   input logic [BANK_AW-1:0]   l_bank,
   input logic [WORD_AW-1:0]   l_addr,
   input logic [NUM_LANES-1:0] l_be,
   input logic [DATA_W-1:0]    l_wdata,
   input logic [DATA_W-1:0]    l_rdata,
   input logic                 l_rvalid,
   input logic                 l_err,
   input logic                 r_cs0_n,
   input logic                 r_cs1,
   input logic                 r_mbox_sel,
   input logic                 r_we,
   input logic [BANK_AW-1:0]   r_bank,
   input logic [WORD_AW-1:0]   r_addr,
   input logic [NUM_LANES-1:0] r_be,
   input logic [DATA_W-1:0]    r_wdata,
   input logic [DATA_W-1:0]    r_rdata,
   input logic                 r_rvalid,
   input logic                 r_err
);
   // R5
   l_rvalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      l_rvalid |-> $past(!l_cs0_n && l_cs1 && !l_mbox_sel && !l_we && (l_be != '0)));
   // R5
   r_rvalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      r_rvalid |-> $past(!r_cs0_n && r_cs1 && !r_mbox_sel && !r_we && (r_be != '0)));
   // R4
   l_err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (l_err && l_rvalid) |-> (l_rdata == '0));
   // R4
   r_err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (r_err && r_rvalid) |-> (r_rdata == '0));
   // R1
   l_err_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      l_err |-> $past(bank_owner_left[l_bank] == 1'b0));
   // R1
   r_err_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      r_err |-> $past(bank_owner_left[r_bank] == 1'b1));
   // R7
   l_err_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
      l_err |-> $past(!l_cs0_n && l_cs1 && !l_mbox_sel));
   // R7
   r_err_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
      r_err |-> $past(!r_cs0_n && r_cs1 && !r_mbox_sel));

   for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
      // R6
      l_lane_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (l_rvalid && !$past(l_be[k])) |-> (l_rdata[k*LANE_W +: LANE_W] == '0));
      // R6
      r_lane_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (r_rvalid && !$past(r_be[k])) |-> (r_rdata[k*LANE_W +: LANE_W] == '0));
   end
endmodule

bind banked_dualport_ram bdp_chk #(
   .DATA_W(DATA_W), .LANE_W(LANE_W), .BANK_AW(BANK_AW), .WORD_AW(WORD_AW)
) u_chk (.*);

// File: tb/sim_banked_dualport_ram.sv
module sim_banked_dualport_ram;
   localparam int DW = 16;
   localparam int AW = 8;
   localparam int BW = 2;
   localparam int NB = 4;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [NB-1:0] owner;
   logic          l_cs0_n, l_cs1, l_mbox_sel, l_we;
   logic [BW-1:0] l_bank;
   logic [AW-1:0] l_addr;
   logic [1:0]    l_be;
   logic [DW-1:0] l_wdata, l_rdata;
   logic          l_rvalid, l_err;
   logic          r_cs0_n, r_cs1, r_mbox_sel, r_we;
   logic [BW-1:0] r_bank;
   logic [AW-1:0] r_addr;
   logic [1:0]    r_be;
   logic [DW-1:0] r_wdata, r_rdata;
   logic          r_rvalid, r_err;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;
   logic [DW-1:0] model [NB][1<<AW];

   always #5 clk = ~clk;

   banked_dualport_ram #(.DATA_W(DW), .LANE_W(8), .BANK_AW(BW), .WORD_AW(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .bank_owner_left(owner),
      .l_cs0_n(l_cs0_n), .l_cs1(l_cs1), .l_mbox_sel(l_mbox_sel), .l_we(l_we),
      .l_bank(l_bank), .l_addr(l_addr), .l_be(l_be), .l_wdata(l_wdata),
      .l_rdata(l_rdata), .l_rvalid(l_rvalid), .l_err(l_err),
      .r_cs0_n(r_cs0_n), .r_cs1(r_cs1), .r_mbox_sel(r_mbox_sel), .r_we(r_we),
      .r_bank(r_bank), .r_addr(r_addr), .r_be(r_be), .r_wdata(r_wdata),
      .r_rdata(r_rdata), .r_rvalid(r_rvalid), .r_err(r_err)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic step;
      @(negedge clk);
   endtask

   task automatic idle;
      l_cs0_n = 1'b1; l_cs1 = 1'b1; l_mbox_sel = 1'b0; l_we = 1'b0;
      l_bank = '0; l_addr = '0; l_be = 2'b11; l_wdata = '0;
      r_cs0_n = 1'b1; r_cs1 = 1'b1; r_mbox_sel = 1'b0; r_we = 1'b0;
      r_bank = '0; r_addr = '0; r_be = 2'b11; r_wdata = '0;
   endtask

   task automatic l_acc(input logic we, input int b, input int a,
                        input logic [1:0] be, input logic [DW-1:0] d);
      l_cs0_n = 1'b0; l_cs1 = 1'b1; l_mbox_sel = 1'b0; l_we = we;
      l_bank = BW'(b); l_addr = AW'(a); l_be = be; l_wdata = d;
   endtask

   task automatic r_acc(input logic we, input int b, input int a,
                        input logic [1:0] be, input logic [DW-1:0] d);
      r_cs0_n = 1'b0; r_cs1 = 1'b1; r_mbox_sel = 1'b0; r_we = we;
      r_bank = BW'(b); r_addr = AW'(a); r_be = be; r_wdata = d;
   endtask

   function automatic logic [DW-1:0] pat(int side, int o, int b, int a);
      return DW'((side << 15) ^ (o * 32'h1111) ^ (b * 32'h0F0F) ^ (a * 7) ^ 32'h0101);
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      owner = '0;
      idle();
      repeat (3) step();
      // R11: outputs quiet in reset
      chk("R11", "l_rvalid", 32'(l_rvalid), 0);
      chk("R11", "l_err", 32'(l_err), 0);
      chk("R11", "l_rdata", 32'(l_rdata), 0);
      chk("R11", "r_rvalid", 32'(r_rvalid), 0);
      chk("R11", "r_err", 32'(r_err), 0);
      chk("R11", "r_rdata", 32'(r_rdata), 0);
      rst_n = 1'b1;
      step();

      // R1 R4 R5 R9 R10: every ownership pattern, both ports on one bank
      for (int o = 0; o < 16; o++) begin
         idle();
         owner = NB'(o);
         step();
         for (int b = 0; b < NB; b++) begin
            for (int ai = 0; ai < 3; ai++) begin
               int a;
               bit lo;
               logic [DW-1:0] lv, rv;
               a  = (ai == 0) ? 0 : (ai == 1) ? 5 : (1 << AW) - 1;
               lo = o[b];
               lv = pat(1, o, b, a);
               rv = pat(0, o, b, a);
               l_acc(1'b1, b, a, 2'b11, lv);
               r_acc(1'b1, b, a, 2'b11, rv);
               step();
               model[b][a] = lo ? lv : rv;
               // R10: blocked writer flags, nobody gets rvalid
               chk("R10", "l_err after write", 32'(l_err), 32'(!lo));
               chk("R10", "r_err after write", 32'(r_err), 32'(lo));
               chk("R10", "l_rvalid after write", 32'(l_rvalid), 0);
               chk("R10", "r_rvalid after write", 32'(r_rvalid), 0);
               l_acc(1'b0, b, a, 2'b11, '0);
               r_acc(1'b0, b, a, 2'b11, '0);
               step();
               idle();
               chk("R5", "l_rvalid", 32'(l_rvalid), 1);
               chk("R5", "r_rvalid", 32'(r_rvalid), 1);
               // R9 R1: owner sees its own data; R4: other side zero + err
               chk("R9", "l_rdata", 32'(l_rdata), lo ? 32'(model[b][a]) : 0);
               chk("R9", "r_rdata", 32'(r_rdata), lo ? 0 : 32'(model[b][a]));
               chk("R4", "l_err", 32'(l_err), 32'(!lo));
               chk("R4", "r_err", 32'(r_err), 32'(lo));
            end
         end
      end

      // R3: lone write from the non-owner
      idle(); owner = 4'hF; step();
      l_acc(1'b1, 3, 4, 2'b11, 16'h1234); step();
      r_acc(1'b1, 3, 4, 2'b11, 16'hDEAD); l_cs0_n = 1'b1; step();
      chk("R3", "r_err on blocked write", 32'(r_err), 1);
      idle(); l_acc(1'b0, 3, 4, 2'b11, '0); step(); idle();
      chk("R3", "owner data kept", 32'(l_rdata), 32'h1234);

      // R2 R6: byte lanes
      l_acc(1'b1, 2, 9, 2'b11, 16'hA5C3); step();
      l_acc(1'b1, 2, 9, 2'b10, 16'h11EE); step();
      l_acc(1'b1, 2, 9, 2'b01, 16'hEE22); step();
      l_acc(1'b1, 2, 9, 2'b00, 16'h7777); step();
      chk("R6", "be=0 write no err", 32'(l_err), 0);
      l_acc(1'b0, 2, 9, 2'b11, '0); step();
      chk("R2", "merged lanes", 32'(l_rdata), 32'h1122);
      l_acc(1'b0, 2, 9, 2'b10, '0); step();
      chk("R6", "upper only read", 32'(l_rdata), 32'h1100);
      l_acc(1'b0, 2, 9, 2'b01, '0); step();
      chk("R6", "lower only read", 32'(l_rdata), 32'h0022);
      l_acc(1'b0, 2, 9, 2'b00, '0); step();
      chk("R6", "be=0 read rvalid", 32'(l_rvalid), 0);
      chk("R6", "be=0 read err", 32'(l_err), 0);

      // R7: each disqualifier blocks write and read
      for (int q = 0; q < 3; q++) begin
         l_acc(1'b1, 2, 9, 2'b11, 16'hFFFF);
         if (q == 0) l_cs0_n = 1'b1;
         if (q == 1) l_cs1 = 1'b0;
         if (q == 2) l_mbox_sel = 1'b1;
         step();
         l_we = 1'b0;
         step();
         chk("R7", "disqualified read rvalid", 32'(l_rvalid), 0);
         chk("R7", "disqualified read err", 32'(l_err), 0);
         l_acc(1'b0, 2, 9, 2'b11, '0); step();
         chk("R7", "data untouched", 32'(l_rdata), 32'h1122);
      end
      // R7: right port disqualified on a bank it does not own: no err
      idle(); r_acc(1'b0, 1, 0, 2'b11, '0); r_mbox_sel = 1'b1; step();
      chk("R7", "r disqualified err", 32'(r_err), 0);

      // R8: different banks, same cycle
      idle(); step(); owner = 4'b0101; step();
      l_acc(1'b1, 0, 3, 2'b11, 16'h0A0A);
      r_acc(1'b1, 1, 3, 2'b11, 16'h0B0B);
      step();
      chk("R8", "l_err", 32'(l_err), 0);
      chk("R8", "r_err", 32'(r_err), 0);
      l_acc(1'b0, 0, 3, 2'b11, '0);
      r_acc(1'b0, 1, 3, 2'b11, '0);
      step(); idle();
      chk("R8", "l_rdata", 32'(l_rdata), 32'h0A0A);
      chk("R8", "r_rdata", 32'(r_rdata), 32'h0B0B);
      step();
      chk("R5", "rvalid drops when idle", 32'(l_rvalid | r_rvalid), 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule